// File: doc/BRIEF.md
# SPI Target Bit Engine with Pause

This block is the bit layer of an SPI target that runs entirely on a fast system clock. The serial clock, chip select, data-in and pause pins are brought into the system domain through synchronisers. Edges are then found by comparing successive samples. Received bits are assembled into bytes, and bytes supplied by a command layer above are serialised onto a data-out pin that has a separate output enable for a three-state pad.

The command layer sees four things: a one-cycle strobe with each received byte, a transmit request at each byte boundary, and one-cycle pulses when a transaction opens and when it closes. It answers a transmit request by presenting a byte and an enable before the next serial-clock falling edge. Instruction decoding lives above this block.

A pause pin (active low) freezes the transfer without losing the bit position. Pausing or resuming takes effect only at a point where the serial clock is low. While paused, the output is released and clock and data activity is ignored.

Top module: `spi_tgt_shifter`

## Requirements
- R1: Data-in is sampled on serial-clock rising edges and shifted in most significant bit first. After the 8th rising edge of a byte, `rx_valid` is high for exactly one system cycle, with the byte on `rx_data`.
- R2: Operation is the same whether the serial clock idles low (mode 0) or high (mode 3). A falling edge that comes before any rising edge of a transaction has no effect.
- R3: `tx_req` pulses in the same cycle as `rx_valid`. At the next falling edge, if `tx_en` is 1, `tx_data` is captured, its bit 7 is driven on `spi_so_d` and `spi_so_oe` goes to 1. Bits 6 down to 0 follow on the next seven falling edges.
- R4: `spi_so_oe` is 0 during the first byte of a transaction, and also for any byte whose load point saw `tx_en` at 0.
- R5: Chip select falling gives a one-cycle `cs_start`, and chip select rising gives a one-cycle `cs_end`. A rise discards a partial byte, restarts the bit count at zero and drops `spi_so_oe`.
- R6: Pause entry happens while the serial clock is low. If the pause pin falls while the clock is high, entry waits for the next falling edge; that falling edge still drives its bit, and then the output is released.
- R7: Pause exit follows the same rule. If the pause pin rises while the clock is high, the block stays paused until the clock is next low.
- R8: While paused, `spi_so_oe` is 0, `spi_so_d` keeps its value, and serial-clock edges and data-in are ignored. After exit the byte continues from the same bit, both for receive and for transmit.
- R9: Chip select going high while paused clears the pause state and the bit count, so the next transaction starts cleanly at bit 7.
- R10: After the synchronous reset, `rx_valid`, `tx_req`, `cs_start`, `cs_end` and `spi_so_oe` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock pin |
| spi_cs_n | input | 1 | Chip select pin, active low |
| spi_si | input | 1 | Serial data in |
| spi_hold_n | input | 1 | Pause pin, active low |
| spi_so_d | output | 1 | Serial data out value |
| spi_so_oe | output | 1 | Output enable for the data-out pad |
| tx_data | input | BYTE_W | Byte to transmit, captured at the load falling edge |
| tx_en | input | 1 | Drive the captured byte (0 leaves the pad released) |
| rx_valid | output | 1 | Received byte strobe |
| rx_data | output | BYTE_W | Received byte |
| tx_req | output | 1 | Byte boundary, next transmit byte wanted |
| cs_start | output | 1 | Transaction opened |
| cs_end | output | 1 | Transaction closed |

## Verification
Some properties are checked on every cycle. The pause state changes only while the synchronised clock is low, unless chip select is clearing it. The output value is frozen and no byte strobe appears while paused. Chip select high releases the pause and the pad within a cycle, the byte strobe is a single-cycle pulse that always comes with a transmit request, and the open and close pulses never coincide. Only the bench's scenarios show the rest: actual bit ordering, deferred pause entry and exit relative to the clock level, resuming at the same bit, behaviour in both clock idle levels, and recovery after an aborted or paused transaction.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;
  typedef struct packed {
    logic sck;
    logic cs_n;
    logic si;
    logic hold_n;
  } spi_pins_t;

  localparam int unsigned PIN_W = $bits(spi_pins_t);
  // idle levels: clock low, deselected, data low, not paused
  localparam logic [PIN_W-1:0] PIN_IDLE = 4'b0101;
endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) q[g] <= RST_VAL;
        else     q[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) q[g] <= RST_VAL;
        else     q[g] <= q[g-1];
      end
    end
  end

  assign dout = q[STAGES-1];
endmodule

// File: rtl/spi_tgt_ctrl.sv
module spi_tgt_ctrl #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic sck_s,
  input  logic cs_n_s,
  input  logic hold_n_s,
  output logic shift_rise,
  output logic shift_fall,
  output logic byte_end,
  output logic held,
  output logic cs_start,
  output logic cs_end
);
  localparam int unsigned CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic             sck_q;
  logic             cs_q;
  logic [CNT_W-1:0] bit_cnt;
  logic             go;

  assign go         = ~cs_n_s & ~held;
  assign shift_rise = go & sck_s & ~sck_q;
  assign shift_fall = go & ~sck_s & sck_q;
  assign byte_end   = shift_rise & (bit_cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q    <= 1'b0;
      cs_q     <= 1'b1;
      cs_start <= 1'b0;
      cs_end   <= 1'b0;
      held     <= 1'b0;
      bit_cnt  <= '0;
    end else begin
      sck_q    <= sck_s;
      cs_q     <= cs_n_s;
      cs_start <= cs_q & ~cs_n_s;
      cs_end   <= ~cs_q & cs_n_s;
      if (cs_n_s) begin
        held    <= 1'b0;
        bit_cnt <= '0;
      end else begin
        if (!sck_s) held <= ~hold_n_s;
        if (shift_rise) bit_cnt <= (bit_cnt == LAST) ? '0 : bit_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_tgt_rx.sv
module spi_tgt_rx #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_rise,
  input  logic              byte_end,
  input  logic              si_s,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_data
);
  logic [BYTE_W-1:0] sr;
  logic [BYTE_W-1:0] sr_next;

  assign sr_next = {sr[BYTE_W-2:0], si_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      sr       <= '0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      rx_valid <= byte_end;
      if (shift_rise) sr <= sr_next;
      if (byte_end) rx_data <= sr_next;
    end
  end
endmodule

// File: rtl/spi_tgt_tx.sv
module spi_tgt_tx #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_fall,
  input  logic              byte_end,
  input  logic              cs_n_s,
  input  logic              held,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_en,
  output logic              so_d,
  output logic              so_oe,
  output logic              tx_req
);
  logic [BYTE_W-1:0] sr;
  logic              pend;
  logic              drive;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr     <= '0;
      pend   <= 1'b0;
      drive  <= 1'b0;
      so_d   <= 1'b0;
      tx_req <= 1'b0;
    end else begin
      tx_req <= byte_end;
      if (cs_n_s) begin
        pend  <= 1'b0;
        drive <= 1'b0;
      end else if (byte_end) begin
        pend <= 1'b1;
      end else if (shift_fall && pend) begin
        pend  <= 1'b0;
        drive <= tx_en;
        if (tx_en) begin
          so_d <= tx_data[BYTE_W-1];
          sr   <= {tx_data[BYTE_W-2:0], 1'b0};
        end
      end else if (shift_fall && drive) begin
        so_d <= sr[BYTE_W-1];
        sr   <= {sr[BYTE_W-2:0], 1'b0};
      end
    end
  end

  assign so_oe = drive & ~held;
endmodule

// File: rtl/spi_tgt_shifter.sv
module spi_tgt_shifter #(
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_si,
  input  logic              spi_hold_n,
  output logic              spi_so_d,
  output logic              spi_so_oe,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_en,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_data,
  output logic              tx_req,
  output logic              cs_start,
  output logic              cs_end
);
  import spi_tgt_pkg::*;

  spi_pins_t pins_raw;
  spi_pins_t pins_s;
  logic      sck_s, cs_n_s, si_s, hold_n_s;
  logic      shift_rise, shift_fall, byte_end, held;

  assign pins_raw = '{sck: spi_sck, cs_n: spi_cs_n, si: spi_si, hold_n: spi_hold_n};

  spi_tgt_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rst(rst), .din(pins_raw), .dout(pins_s)
  );

  assign sck_s    = pins_s.sck;
  assign cs_n_s   = pins_s.cs_n;
  assign si_s     = pins_s.si;
  assign hold_n_s = pins_s.hold_n;

  spi_tgt_ctrl #(.BYTE_W(BYTE_W)) u_ctrl (
    .clk(clk), .rst(rst), .sck_s(sck_s), .cs_n_s(cs_n_s), .hold_n_s(hold_n_s),
    .shift_rise(shift_rise), .shift_fall(shift_fall), .byte_end(byte_end),
    .held(held), .cs_start(cs_start), .cs_end(cs_end)
  );

  spi_tgt_rx #(.BYTE_W(BYTE_W)) u_rx (
    .clk(clk), .rst(rst), .shift_rise(shift_rise), .byte_end(byte_end),
    .si_s(si_s), .rx_valid(rx_valid), .rx_data(rx_data)
  );

  spi_tgt_tx #(.BYTE_W(BYTE_W)) u_tx (
    .clk(clk), .rst(rst), .shift_fall(shift_fall), .byte_end(byte_end),
    .cs_n_s(cs_n_s), .held(held), .tx_data(tx_data), .tx_en(tx_en),
    .so_d(spi_so_d), .so_oe(spi_so_oe), .tx_req(tx_req)
  );
endmodule

// File: rtl/spi_tgt_shifter_chk.sv
module spi_tgt_shifter_chk (
  input logic clk,
  input logic rst,
  input logic sck_s,
  input logic cs_n_s,
  input logic held,
  input logic so_d,
  input logic so_oe,
  input logic rx_valid,
  input logic tx_req,
  input logic cs_start,
  input logic cs_end
);
  // R9: deselect always clears the pause state
  p_cs_clears_hold_r9: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |=> !held);

  // R6 / R7: pause changes only at a clock-low point (or by deselect)
  p_hold_at_low_r6: assert property (@(posedge clk) disable iff (rst)
    (held != $past(held)) |-> (!$past(sck_s) || $past(cs_n_s)));

  // R8: data-out value frozen while paused
  p_so_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    (held && $past(held)) |-> $stable(so_d));

  // R8: no byte completes while paused
  p_no_rx_in_hold_r8: assert property (@(posedge clk) disable iff (rst)
    held |-> !rx_valid);

  // R1: byte strobe lasts a single cycle
  p_rx_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R3: transmit request accompanies each received byte
  p_req_with_rx_r3: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> tx_req);

  // R5: pad released once deselected; open/close pulses never coincide
  p_oe_off_idle_r5: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |=> !so_oe);

  p_cs_events_r5: assert property (@(posedge clk) disable iff (rst)
    !(cs_start && cs_end));
endmodule

bind spi_tgt_shifter spi_tgt_shifter_chk u_chk (
  .clk(clk), .rst(rst), .sck_s(sck_s), .cs_n_s(cs_n_s), .held(held),
  .so_d(spi_so_d), .so_oe(spi_so_oe), .rx_valid(rx_valid), .tx_req(tx_req),
  .cs_start(cs_start), .cs_end(cs_end)
);

// File: tb/spi_tgt_shifter_bench.sv
module spi_tgt_shifter_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       spi_sck = 1'b0;
  logic       spi_cs_n = 1'b1;
  logic       spi_si = 1'b0;
  logic       spi_hold_n = 1'b1;
  logic [7:0] tx_data = 8'h00;
  logic       tx_en = 1'b0;
  logic       spi_so_d, spi_so_oe, rx_valid, tx_req, cs_start, cs_end;
  logic [7:0] rx_data;

  int checks = 0;
  int failures = 0;
  int n_rx = 0, n_req = 0, n_start = 0, n_end = 0;
  logic [7:0] last_rx = 8'h00;
  bit done = 1'b0;

  always #10 clk = ~clk;

  spi_tgt_shifter u_spi_tgt_shifter (
    .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_si(spi_si),
    .spi_hold_n(spi_hold_n), .spi_so_d(spi_so_d), .spi_so_oe(spi_so_oe),
    .tx_data(tx_data), .tx_en(tx_en), .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_req(tx_req), .cs_start(cs_start), .cs_end(cs_end)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid) begin n_rx++; last_rx = rx_data; end
      if (tx_req) n_req++;
      if (cs_start) n_start++;
      if (cs_end) n_end++;
    end
  end

  // {idle_high, tx_en, byte0, byte1, tx_byte}
  localparam logic [25:0] VEC [6] = '{
    {1'b0, 1'b1, 8'hA5, 8'h3C, 8'h96},
    {1'b1, 1'b1, 8'h01, 8'hFF, 8'h81},
    {1'b0, 1'b0, 8'h80, 8'h7E, 8'hFF},
    {1'b1, 1'b0, 8'hFF, 8'h00, 8'h55},
    {1'b0, 1'b1, 8'h00, 8'hC9, 8'h00},
    {1'b1, 1'b1, 8'h5A, 8'hE7, 8'hFF}
  };

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bit_io(input logic b, output logic o, output logic oe);
    spi_si  = b;
    spi_sck = 1'b0;
    wait_clk(6);
    o  = spi_so_d;
    oe = spi_so_oe;
    spi_sck = 1'b1;
    wait_clk(6);
  endtask

  task automatic xfer(input logic [7:0] mo, output logic [7:0] mi,
                      output logic oe_all, output logic oe_none);
    logic o, oe;
    oe_all = 1'b1; oe_none = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      bit_io(mo[i], o, oe);
      mi[i] = o;
      if (oe) oe_none = 1'b0; else oe_all = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [7:0] mi;
    logic oe_all, oe_none, o, oe;
    int rx0, st0, en0;

    wait_clk(4);
    rst = 1'b0;
    wait_clk(1);
    // R10 reset state
    chk(!rx_valid && !tx_req, "R10 strobes", {rx_valid, tx_req}, 0);
    chk(!cs_start && !cs_end, "R10 cs events", {cs_start, cs_end}, 0);
    chk(!spi_so_oe, "R10 oe", spi_so_oe, 0);
    wait_clk(6);

    // table of transactions: R1 R2 R3 R4
    foreach (VEC[k]) begin
      logic [25:0] v;
      v = VEC[k];
      spi_sck = v[25]; tx_en = v[24]; tx_data = v[7:0];
      wait_clk(8);
      rx0 = n_rx; st0 = n_start;
      spi_cs_n = 1'b0;
      wait_clk(8);
      chk(n_start == st0 + 1, "R5 start pulse", n_start, st0 + 1);
      xfer(v[23:16], mi, oe_all, oe_none);
      wait_clk(2);
      chk(last_rx == v[23:16], "R1 byte0", last_rx, v[23:16]);
      chk(oe_none, "R4 first byte released", oe_none, 1);
      xfer(v[15:8], mi, oe_all, oe_none);
      wait_clk(2);
      chk(last_rx == v[15:8], "R2 byte1 both idles", last_rx, v[15:8]);
      chk(n_rx == rx0 + 2 && n_req == n_rx, "R3 req count", n_req, n_rx);
      if (v[24]) begin
        chk(oe_all, "R3 oe driven", oe_all, 1);
        chk(mi == v[7:0], "R3 tx bits", mi, v[7:0]);
      end else begin
        chk(oe_none, "R4 tx disabled", oe_none, 1);
      end
      spi_sck = v[25];
      wait_clk(8);
      en0 = n_end;
      spi_cs_n = 1'b1;
      wait_clk(8);
      chk(n_end == en0 + 1 && !spi_so_oe, "R5 end pulse", n_end, en0 + 1);
    end

    // R5: partial byte discarded by deselect
    spi_sck = 1'b0; tx_en = 1'b1; tx_data = 8'hC3;
    wait_clk(8);
    spi_cs_n = 1'b0; wait_clk(8);
    for (int i = 0; i < 3; i++) bit_io(1'b1, o, oe);
    spi_sck = 1'b0; wait_clk(6);
    spi_cs_n = 1'b1; wait_clk(8);
    rx0 = n_rx;
    spi_cs_n = 1'b0; wait_clk(8);
    xfer(8'h5A, mi, oe_all, oe_none);
    wait_clk(2);
    chk(last_rx == 8'h5A && n_rx == rx0 + 1, "R5 restart after abort", last_rx, 8'h5A);

    // R6 / R7 / R8: deferred pause mid byte, tx 0xC3, rx 0xA6
    for (int i = 7; i >= 5; i--) begin
      bit_io(i[0] ? 1'b1 : 1'b0, o, oe);
      mi[i] = o;
    end
    // bits sent so far: 1,0,1 (A6 = 1010_0110)
    spi_hold_n = 1'b0; wait_clk(6);
    chk(spi_so_oe, "R6 entry deferred while clock high", spi_so_oe, 1);
    spi_si = 1'b0; spi_sck = 1'b0; wait_clk(6);
    chk(!spi_so_oe, "R6 entry at clock low", spi_so_oe, 0);
    chk(spi_so_d == 1'b0, "R6 fall drove bit4", spi_so_d, 0);
    rx0 = n_rx;
    for (int i = 0; i < 2; i++) begin
      spi_si = ~spi_si; spi_sck = 1'b1; wait_clk(6);
      spi_sck = 1'b0; wait_clk(6);
    end
    spi_sck = 1'b1; wait_clk(6);
    spi_hold_n = 1'b1; wait_clk(6);
    chk(!spi_so_oe, "R7 exit deferred while clock high", spi_so_oe, 0);
    spi_sck = 1'b0; wait_clk(6);
    chk(spi_so_oe && spi_so_d == 1'b0, "R7 exit at clock low", {spi_so_oe, spi_so_d}, 2'b10);
    chk(n_rx == rx0, "R8 no rx while paused", n_rx, rx0);
    mi[4] = spi_so_d;
    spi_si = 1'b0; wait_clk(6);
    spi_sck = 1'b1; wait_clk(6);
    for (int i = 3; i >= 0; i--) begin
      bit_io((8'hA6 >> i) & 1, o, oe);
      mi[i] = o;
    end
    wait_clk(2);
    chk(last_rx == 8'hA6 && n_rx == rx0 + 1, "R8 rx resumes same bit", last_rx, 8'hA6);
    chk(mi == 8'hC3, "R8 tx resumes same bit", mi, 8'hC3);

    // R6: immediate entry with clock low, toggles ignored
    spi_sck = 1'b0; wait_clk(6);
    spi_hold_n = 1'b0; wait_clk(6);
    rx0 = n_rx;
    for (int i = 0; i < 8; i++) bit_io(1'b1, o, oe);
    spi_sck = 1'b0; wait_clk(6);
    chk(n_rx == rx0, "R6 immediate pause ignores clock", n_rx, rx0);
    spi_hold_n = 1'b1; wait_clk(6);
    xfer(8'h3C, mi, oe_all, oe_none);
    wait_clk(2);
    chk(last_rx == 8'h3C && n_rx == rx0 + 1, "R8 byte after pause", last_rx, 8'h3C);

    // R9: deselect while paused
    for (int i = 0; i < 5; i++) bit_io(1'b0, o, oe);
    spi_hold_n = 1'b0; spi_sck = 1'b0; wait_clk(6);
    en0 = n_end;
    spi_cs_n = 1'b1; wait_clk(8);
    spi_hold_n = 1'b1; wait_clk(4);
    chk(n_end == en0 + 1, "R9 end during pause", n_end, en0 + 1);
    rx0 = n_rx;
    spi_cs_n = 1'b0; wait_clk(8);
    xfer(8'h96, mi, oe_all, oe_none);
    wait_clk(2);
    chk(last_rx == 8'h96 && n_rx == rx0 + 1, "R9 clean restart", last_rx, 8'h96);
    spi_sck = 1'b0; wait_clk(6);
    spi_cs_n = 1'b1; wait_clk(8);

    done = 1'b1;
    finish_run();
  end
endmodule